// File: doc/BRIEF.md
# Segmented Current-DAC Decoder with Rotating Calibration

This block turns a 16-bit two's complement audio sample into the switch controls of a segmented current DAC. The converter has thirty-three physical unit sources of equal weight plus a binary divider that splits one further unit into eleven fine bits. Each sample becomes a count of unit sources to turn fully on, the physical number of the source that feeds the divider, and an 11-bit fine code. A bias of half a unit is added before splitting, so stepping from code -1 to code 0 changes only the fine code and never switches a unit source.

At any time one physical source is taken out of service for recalibration. The remaining thirty-two sources fill the logical slots in physical order, skipping the one under calibration, so the converter keeps producing output without a gap. A cycle timer marks when the calibration slot should move on, and the move is applied at the next sample strobe. This way the mapping of physical sources to logical slots never changes in the middle of a sample. All outputs are registered and change together, one clock after a strobe.

Top module: `segdac_rotator`

## Requirements
- R1: On a strobe, with u = sample + 33792 (sample read as signed), the block outputs fine code u mod 2048 and enables floor(u / 2048) unit sources, provided that quotient is at most 31.
- R2: When the quotient reaches 32 (samples 31744 and above), the enabled count is clamped to 31 and the fine code to 2047, so 31743 and any larger sample produce the same outputs.
- R3: Samples -1 and 0 under the same calibration slot give identical source enables and divider index, and fine codes of 1023 and 1024.
- R4: Physical sources are numbered 0 to 32 and r is the one under calibration. Source p < r holds logical slot p and source p > r holds slot p-1. A source is enabled exactly when its slot is below the enabled count.
- R5: The divider index is the physical source holding slot c, where c is the enabled count: c when c < r, else c+1. That source is neither enabled nor under calibration.
- R6: The calibrate output has exactly one bit set, at position r, and that source is never enabled.
- R7: A timer counts clock cycles from reset. At the end of each CAL_PERIOD-cycle window a move becomes due. The next strobe, including one in that same last cycle, advances r by one, wrapping from 32 to 0. Several windows without a strobe still give one step.
- R8: Without a strobe every output holds its value, and the sample input is ignored.
- R9: During and after reset, r is 0: the calibrate output is bit 0, no source is enabled, the divider index is 1 and the fine code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; outputs update one clock later |
| smp_data | input | 16 | Two's complement sample |
| src_en | output | 33 | Per physical source: drive the source fully into the output |
| src_cal | output | 33 | One-hot: physical source currently under calibration |
| div_src | output | 6 | Physical source routed to the binary divider |
| fine_code | output | 11 | Divider bit controls |

## Verification
Two things can fall on the same clock edge: a calibration move becoming due and a sample strobe. The move must then be applied together with that sample's decode, so the source taken offline and the new enable pattern appear in the same registered word. The stimulus uses a short calibration window and strobes both on consecutive cycles and after gaps longer than the window, so strobes land on, before and after the end of a window. A bench model of the timer predicts r for every strobe. Each output word is compared with an expected word computed from that r and from the arithmetic in the requirements.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    localparam int SAMPLE_W    = 16;
    localparam int FINE_W      = 11;
    localparam int COARSE_BITS = SAMPLE_W - FINE_W;
    localparam int COARSE_N    = 2 ** COARSE_BITS;
    localparam int NSRC        = COARSE_N + 1;
    localparam int IDX_W       = $clog2(NSRC);

    typedef struct packed {
        logic [COARSE_BITS-1:0] count;
        logic [FINE_W-1:0]      fine;
    } seg_code_t;

    typedef struct packed {
        logic [NSRC-1:0]   en;
        logic [NSRC-1:0]   cal;
        logic [IDX_W-1:0]  div;
        logic [FINE_W-1:0] fine;
    } dac_ctrl_t;

    function automatic logic [IDX_W-1:0] rot_step(input logic [IDX_W-1:0] r);
        return (r == IDX_W'(NSRC - 1)) ? '0 : r + IDX_W'(1);
    endfunction
endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import segdac_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    output seg_code_t           code
);
    localparam logic [SAMPLE_W:0] BIAS = (SAMPLE_W+1)'(1) << (FINE_W - 1);

    logic [SAMPLE_W:0] biased;

    always_comb begin
        biased = {1'b0, ~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]} + BIAS;
        if (biased[SAMPLE_W]) begin
            code.count = '1;
            code.fine  = '1;
        end else begin
            code.count = biased[SAMPLE_W-1:FINE_W];
            code.fine  = biased[FINE_W-1:0];
        end
    end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import segdac_pkg::*;
#(
    parameter int CAL_PERIOD = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    output logic [IDX_W-1:0] rot_use
);
    localparam int TW = (CAL_PERIOD > 1) ? $clog2(CAL_PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(CAL_PERIOD - 1);

    logic [TW-1:0]    tmr_q;
    logic             pend_q;
    logic [IDX_W-1:0] rot_q;
    logic             tick, due;

    always_comb begin
        tick    = (tmr_q == LAST);
        due     = pend_q | tick;
        rot_use = (strobe && due) ? rot_step(rot_q) : rot_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q  <= '0;
            pend_q <= 1'b0;
            rot_q  <= '0;
        end else begin
            tmr_q <= tick ? '0 : tmr_q + TW'(1);
            if (strobe) begin
                rot_q  <= rot_use;
                pend_q <= 1'b0;
            end else begin
                pend_q <= due;
            end
        end
    end

    a_r7_rot_range: assert property (@(posedge clk) disable iff (rst)
        rot_q < IDX_W'(NSRC));
    a_r7_due_moves: assert property (@(posedge clk) disable iff (rst)
        (strobe && due) |=> (rot_q != $past(rot_q)));
endmodule

// File: rtl/src_mapper.sv
module src_mapper
    import segdac_pkg::*;
(
    input  logic [IDX_W-1:0]       rot,
    input  logic [COARSE_BITS-1:0] count,
    output logic [NSRC-1:0]        en,
    output logic [NSRC-1:0]        cal,
    output logic [IDX_W-1:0]       div
);
    logic [IDX_W-1:0] cnt_x;
    assign cnt_x = IDX_W'(count);
    assign div   = (cnt_x < rot) ? cnt_x : cnt_x + IDX_W'(1);

    for (genvar p = 0; p < NSRC; p++) begin : g_src
        localparam logic [IDX_W-1:0] PIDX = IDX_W'(p);
        logic [IDX_W-1:0] slot;
        always_comb begin
            slot   = (PIDX < rot) ? PIDX : PIDX - IDX_W'(1);
            cal[p] = (PIDX == rot);
            en[p]  = (PIDX != rot) && (slot < cnt_x);
        end
    end
endmodule

// File: rtl/segdac_rotator.sv
module segdac_rotator
    import segdac_pkg::*;
#(
    parameter int CAL_PERIOD = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [NSRC-1:0]     src_en,
    output logic [NSRC-1:0]     src_cal,
    output logic [IDX_W-1:0]    div_src,
    output logic [FINE_W-1:0]   fine_code
);
    seg_code_t        code;
    logic [IDX_W-1:0] rot_use;
    dac_ctrl_t        nxt, ctrl_q;

    seg_decode u_dec (.sample(smp_data), .code(code));

    cal_sequencer #(.CAL_PERIOD(CAL_PERIOD)) u_seq (
        .clk(clk), .rst(rst), .strobe(smp_valid), .rot_use(rot_use));

    src_mapper u_map (
        .rot(rot_use), .count(code.count),
        .en(nxt.en), .cal(nxt.cal), .div(nxt.div));

    assign nxt.fine = code.fine;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.en   <= '0;
            ctrl_q.cal  <= NSRC'(1);
            ctrl_q.div  <= IDX_W'(1);
            ctrl_q.fine <= '0;
        end else if (smp_valid) begin
            ctrl_q <= nxt;
        end
    end

    assign src_en    = ctrl_q.en;
    assign src_cal   = ctrl_q.cal;
    assign div_src   = ctrl_q.div;
    assign fine_code = ctrl_q.fine;

    a_r6_cal_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(src_cal) == 1);
    a_r6_cal_not_driven: assert property (@(posedge clk) disable iff (rst)
        (src_en & src_cal) == '0);
    a_r5_div_free: assert property (@(posedge clk) disable iff (rst)
        !src_en[div_src] && !src_cal[div_src]);
    a_r4_en_limit: assert property (@(posedge clk) disable iff (rst)
        $countones(src_en) <= COARSE_N - 1);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(src_en) && $stable(src_cal) && $stable(div_src) && $stable(fine_code)));
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (src_cal == $past(src_cal)
                    || src_cal == {$past(src_cal[NSRC-2:0]), $past(src_cal[NSRC-1])}));
endmodule

// File: tb/tb_segdac_rotator.sv
module tb_segdac_rotator;
    localparam int P = 16;

    typedef struct packed {
        logic [32:0] en;
        logic [32:0] cal;
        logic [5:0]  div;
        logic [10:0] fine;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [32:0] src_en, src_cal;
    logic [5:0]  div_src;
    logic [10:0] fine_code;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    logic chk_flag = 1'b0;

    int m_cnt = 0, m_pend = 0, m_rot = 0;

    always #4 clk = ~clk;

    segdac_rotator #(.CAL_PERIOD(P)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .src_en(src_en), .src_cal(src_cal), .div_src(div_src), .fine_code(fine_code));

    // timer model (R7)
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pend = 0; m_rot = 0;
        end else begin
            automatic bit tick = (m_cnt == P - 1);
            m_cnt = tick ? 0 : m_cnt + 1;
            if (smp_valid) begin
                if (m_pend != 0 || tick) m_rot = (m_rot + 1) % 33;
                m_pend = 0;
            end else if (tick) m_pend = 1;
        end
    end

    always @(posedge clk) chk_flag <= smp_valid && !rst;

    function automatic exp_t expect_for(input logic [15:0] d, input int r);
        exp_t e;
        int u, c, f;
        u = int'($signed(d)) + 33792;
        c = u / 2048;
        f = u % 2048;
        if (c > 31) begin c = 31; f = 2047; end
        e.en = '0;
        e.cal = '0;
        e.cal[r] = 1'b1;
        for (int p = 0; p < 33; p++) begin
            int slot;
            slot = (p < r) ? p : p - 1;
            if (p != r && slot < c) e.en[p] = 1'b1;
        end
        e.div  = 6'((c < r) ? c : c + 1);
        e.fine = 11'(f);
        return e;
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (chk_flag && q.size() > 0) begin
            automatic exp_t e = q.pop_front();
            check("R4 enables", 64'(src_en), 64'(e.en));
            check("R6 R7 calibrate", 64'(src_cal), 64'(e.cal));
            check("R5 divider", 64'(div_src), 64'(e.div));
            check("R1 fine", 64'(fine_code), 64'(e.fine));
        end
    end

    // driver: called at a negedge, returns at the next negedge
    task automatic drive(input logic [15:0] d);
        automatic int due = (m_pend != 0 || m_cnt == P - 1) ? 1 : 0;
        automatic int r = due ? (m_rot + 1) % 33 : m_rot;
        smp_valid = 1'b1;
        smp_data  = d;
        q.push_back(expect_for(d, r));
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [15:0] d);
        smp_valid = 1'b0;
        smp_data  = d;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [32:0] en_a, cal_a;
        logic [5:0]  div_a;
        logic [10:0] fine_a;
        logic [15:0] lfsr;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset en", 64'(src_en), 64'(0));
        check("R9 reset cal", 64'(src_cal), 64'(1));
        check("R9 reset div", 64'(div_src), 64'(1));
        check("R9 reset fine", 64'(fine_code), 64'(0));
        rst = 1'b0;

        // R3: zero crossing touches only fine bits
        drive(16'hFFFF);
        en_a = src_en; cal_a = src_cal; div_a = div_src; fine_a = fine_code;
        drive(16'h0000);
        check("R3 cal same", 64'(src_cal), 64'(cal_a));
        check("R3 en same", 64'(src_en), 64'(en_a));
        check("R3 div same", 64'(div_src), 64'(div_a));
        check("R3 fine at -1", 64'(fine_a), 64'(1023));
        check("R3 fine at 0", 64'(fine_code), 64'(1024));

        // R2: clamp region
        drive(16'h7BFF);
        en_a = src_en; fine_a = fine_code;
        check("R2 count 31", 64'($countones(src_en)), 64'(31));
        check("R2 fine 2047", 64'(fine_a), 64'(2047));
        drive(16'h7C00);
        check("R2 clamp start", 64'(fine_code), 64'(2047));
        check("R2 clamp count", 64'($countones(src_en)), 64'(31));
        drive(16'h7FFF);
        check("R2 max clamp", 64'(fine_code), 64'(2047));
        drive(16'h8000);
        check("R1 minimum count", 64'($countones(src_en)), 64'(0));

        // R8: no strobe, changing data, longer than a window
        drive(16'h1234);
        en_a = src_en; cal_a = src_cal; div_a = div_src; fine_a = fine_code;
        idle(2 * P + 5, 16'hA5A5);
        check("R8 hold en", 64'(src_en), 64'(en_a));
        check("R8 hold cal", 64'(src_cal), 64'(cal_a));
        check("R8 hold div", 64'(div_src), 64'(div_a));
        check("R8 hold fine", 64'(fine_code), 64'(fine_a));
        // R7: after several windows, exactly one step
        drive(16'h1234);
        check("R7 single step", 64'(src_cal), 64'({cal_a[31:0], cal_a[32]}));

        // mixed stream with gaps
        lfsr = 16'hACE1;
        for (int i = 0; i < 1200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr);
            if (i % 7 == 3) idle(i % 23, ~lfsr);
        end
        idle(2, 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule